// File: doc/BRIEF.md
# Serial Flash Status Register Responder

This block is the device-side command logic for the status registers of a serial flash. It listens on a four-wire SPI link in clock mode 0 or mode 3 and serves five commands. Two read one of the two 8-bit status registers. One arms the write-enable latch. One arms a single write to the volatile copy only. One writes the status registers. All SPI pins are sampled by the block's own system clock, so the whole design runs in one clock domain.

The writable status bits are held twice. A non-volatile copy survives `rst_n`, which models a power cycle. A volatile working copy drives every read and is reloaded from the non-volatile copy on each `rst_n`. A status write can target either copy. Four bits are one-time: once they read 1 they stay 1. A non-volatile write holds the busy flag for a fixed number of clock cycles. Status reads are served at all times, so a host can poll the busy flag inside one continuous read.

Top module: `flash_sr_resp`

## Requirements
- R1: `mosi` is sampled on rising `sclk` edges. Read data is driven on falling edges, MSB first. `miso_oe` is 0 while `cs_n` is high and during opcode shifting, and is 1 while read bits are being shifted out.
- R2: Status word layout, with register 1 as bits 7:0 and register 2 as bits 15:8: bit 0 is busy, bit 1 is the write-enable latch, bits 7:2 are a writable protection field, bits 9:8 and 14:11 are writable, and bits 10 and 15 always read 0. Opcode 05h returns register 1 and opcode 35h returns register 2.
- R3: While `cs_n` stays low after a read opcode, the selected register is sent again byte after byte. Each byte is captured live at the first falling edge of that byte.
- R4: Opcode 06h sets the write-enable latch (bit 1).
- R5: Opcode 01h takes effect at the rising edge of `cs_n` only if exactly 8 or 16 data bits followed the opcode. The first byte goes to register 1 and the second byte to register 2. Any other bit count discards the write, and bits outside the writable set never change.
- R6: A 01h write with the latch set and no volatile arm updates the non-volatile copy and the volatile copy. It then holds busy for `BUSY_CYC` clock cycles, and when busy ends both busy and the latch clear. A 01h write with neither enable armed is discarded.
- R7: After opcode 50h, the next 01h write updates only the volatile copy, and the latch stays 0. The arm is used up by that 01h, and any other opcode clears it.
- R8: Bits 8, 11, 12 and 13 are one-time in both copies: a write can set them but never clear them.
- R9: A low `rst_n` reloads the volatile copy from the non-volatile copy and clears the latch, busy and the volatile arm. A low `nv_init_n` loads the non-volatile copy with `NV_INIT`.
- R10: While busy is 1, opcodes 06h, 50h and 01h have no effect. Reads are still served.
- R11: An unknown opcode is ignored, and `miso_oe` stays 0 until `cs_n` goes high.
- R12: Reads work the same whether `sclk` idles low (mode 0) or high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| nv_init_n | input | 1 | Active-low load of the non-volatile copy with NV_INIT |
| rst_n | input | 1 | Active-low power-on reset (volatile reload) |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI clock |
| mosi | input | 1 | SPI data into the block |
| miso | output | 1 | SPI data out of the block |
| miso_oe | output | 1 | Output enable for miso (0 means high impedance) |

## Verification
A wrong volatile word or a wrong one-time bit shows up on the very next 05h or 35h read. A fault in the non-volatile copy stays hidden until `rst_n` pulses and the reload brings it to the pins, so the bench resets after every group of non-volatile writes. A busy timer or latch-clear fault shows as a wrong count of busy bytes, or a wrong latch value, inside one continuous polling read. A miscounted data length shows as a write landing when it should have been discarded.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;

    // Writable bits of the 16-bit status word {reg2, reg1}
    localparam logic [15:0] WR_MASK  = 16'h7BFC;
    // One-time bits: once 1, never cleared
    localparam logic [15:0] OTP_MASK = 16'h3900;

    localparam logic [7:0] OP_RD1   = 8'h05;
    localparam logic [7:0] OP_RD2   = 8'h35;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_VWREN = 8'h50;
    localparam logic [7:0] OP_WRSR  = 8'h01;

    typedef enum logic [1:0] {PH_OPC, PH_RD, PH_WR, PH_IGN} phase_e;

    // Merge shifted write data into a status image.
    // With two bytes, shreg[15:8] holds the register 1 byte and shreg[7:0] the register 2 byte.
    function automatic logic [15:0] sr_merge(input logic [15:0] old,
                                             input logic [15:0] shreg,
                                             input logic        two_bytes);
        logic [15:0] mask;
        logic [15:0] pos;
        mask = two_bytes ? WR_MASK : {8'h00, WR_MASK[7:0]};
        pos  = two_bytes ? {shreg[7:0], shreg[15:8]} : {8'h00, shreg[7:0]};
        return (old & ~mask) | (pos & mask) | (old & OTP_MASK);
    endfunction

endpackage

// File: rtl/flash_sr_sampler.sv
module flash_sr_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic cs_s,
    output logic mosi_s,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise
);
    typedef struct packed {
        logic cs;
        logic sclk;
        logic mosi;
        logic cs_p;
        logic sclk_p;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.cs     = cs_n;
        s_d.sclk   = sclk;
        s_d.mosi   = mosi;
        s_d.cs_p   = s_q.cs;
        s_d.sclk_p = s_q.sclk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{cs: 1'b1, sclk: 1'b0, mosi: 1'b0, cs_p: 1'b1, sclk_p: 1'b0};
        else        s_q <= s_d;
    end

    assign cs_s      = s_q.cs;
    assign mosi_s    = s_q.mosi;
    assign sclk_rise = s_q.sclk & ~s_q.sclk_p;
    assign sclk_fall = ~s_q.sclk & s_q.sclk_p;
    assign cs_rise   = s_q.cs & ~s_q.cs_p;
endmodule

// File: rtl/flash_sr_busy_timer.sv
module flash_sr_busy_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/flash_sr_resp.sv
module flash_sr_resp
    import flash_sr_pkg::*;
#(
    parameter int          BUSY_CYC = 1000,
    parameter logic [15:0] NV_INIT  = 16'h0000
) (
    input  logic clk,
    input  logic nv_init_n,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);
    localparam int          BW      = 5;
    localparam logic [BW-1:0] BCAP  = '1;
    localparam logic [BW-1:0] OPC_LAST = BW'(7);
    localparam logic [BW-1:0] LEN8  = BW'(16);
    localparam logic [BW-1:0] LEN16 = BW'(24);

    typedef struct packed {
        phase_e        phase;
        logic [BW-1:0] bcnt;
        logic [15:0]   sh;
        logic          sel2;
        logic          wr_vol;
        logic [7:0]    rd_sh;
        logic [2:0]    rd_cnt;
        logic          oe;
        logic          miso;
        logic          wel;
        logic          vol_en;
        logic [15:0]   vol;
    } st_t;

    st_t         st_d, st_q;
    logic [15:0] nv_d, nv_q;

    logic cs_s, mosi_s, sclk_rise, sclk_fall, cs_rise;
    logic busy, busy_done, busy_start;
    logic rst_all_n;
    logic two;
    logic [7:0]  opc;
    logic [7:0]  byte_now;
    logic [15:0] sr_now;

    assign rst_all_n = rst_n & nv_init_n;

    flash_sr_sampler u_smp (
        .clk(clk), .rst_n(rst_all_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .cs_s(cs_s), .mosi_s(mosi_s), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .cs_rise(cs_rise)
    );

    flash_sr_busy_timer #(.CYCLES(BUSY_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_all_n), .start(busy_start),
        .busy(busy), .done(busy_done)
    );

    function automatic st_t st_reset(input logic [15:0] img);
        st_t r;
        r        = '0;
        r.phase  = PH_OPC;
        r.vol    = img & WR_MASK;
        return r;
    endfunction

    always_comb begin
        st_d       = st_q;
        nv_d       = nv_q;
        busy_start = 1'b0;
        two        = (st_q.bcnt == LEN16);
        opc        = {st_q.sh[6:0], mosi_s};
        sr_now     = {1'b0, st_q.vol[14:11], 1'b0, st_q.vol[9:2], st_q.wel, busy};
        byte_now   = st_q.sel2 ? sr_now[15:8] : sr_now[7:0];

        if (busy_done) st_d.wel = 1'b0;

        if (cs_s) begin
            // write commits on deselect after a whole number of data bytes
            if (cs_rise && st_q.phase == PH_WR &&
                (st_q.bcnt == LEN8 || st_q.bcnt == LEN16)) begin
                st_d.vol = sr_merge(st_q.vol, st_q.sh, two);
                if (!st_q.wr_vol) begin
                    nv_d       = sr_merge(nv_q, st_q.sh, two);
                    busy_start = 1'b1;
                end
            end
            st_d.phase  = PH_OPC;
            st_d.bcnt   = '0;
            st_d.rd_cnt = '0;
            st_d.oe     = 1'b0;
        end else begin
            if (sclk_rise) begin
                st_d.sh = {st_q.sh[14:0], mosi_s};
                if (st_q.bcnt != BCAP) st_d.bcnt = st_q.bcnt + BW'(1);
                if (st_q.bcnt == OPC_LAST) begin
                    st_d.vol_en = 1'b0;
                    st_d.phase  = PH_IGN;
                    case (opc)
                        OP_RD1, OP_RD2: begin
                            st_d.phase = PH_RD;
                            st_d.sel2  = (opc == OP_RD2);
                        end
                        OP_WREN:  if (!busy) st_d.wel = 1'b1;
                        OP_VWREN: if (!busy) st_d.vol_en = 1'b1;
                        OP_WRSR: begin
                            if (!busy && (st_q.vol_en || st_q.wel)) begin
                                st_d.phase  = PH_WR;
                                st_d.wr_vol = st_q.vol_en;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            if (sclk_fall && st_q.phase == PH_RD) begin
                st_d.oe = 1'b1;
                if (st_q.rd_cnt == 3'd0) begin
                    st_d.miso  = byte_now[7];
                    st_d.rd_sh = {byte_now[6:0], 1'b0};
                end else begin
                    st_d.miso  = st_q.rd_sh[7];
                    st_d.rd_sh = {st_q.rd_sh[6:0], 1'b0};
                end
                st_d.rd_cnt = st_q.rd_cnt + 3'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!nv_init_n) nv_q <= NV_INIT & WR_MASK;
        else            nv_q <= nv_d;
    end

    always_ff @(posedge clk) begin
        if (!nv_init_n)  st_q <= st_reset(NV_INIT);
        else if (!rst_n) st_q <= st_reset(nv_q);
        else             st_q <= st_d;
    end

    // views for the bound checker
    logic [15:0] vol_w;
    logic        wel_w;
    logic        rd_phase_w;
    assign vol_w      = st_q.vol;
    assign wel_w      = st_q.wel;
    assign rd_phase_w = (st_q.phase == PH_RD);

    assign miso    = st_q.miso;
    assign miso_oe = st_q.oe;
endmodule

// File: rtl/flash_sr_resp_chk.sv
module flash_sr_resp_chk
    import flash_sr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        nv_init_n,
    input logic        cs_s,
    input logic        miso_oe,
    input logic        rd_phase,
    input logic [15:0] vol,
    input logic [15:0] nv,
    input logic        busy,
    input logic        wel
);
    // R1: deselect turns the output driver off on the following cycle
    a_r1_oe_off_deselect: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        cs_s |=> !miso_oe);

    // R1 / R11: driver only on during a read command
    a_r11_oe_only_read: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        miso_oe |-> rd_phase);

    // R8: one-time bits never fall in the volatile copy
    a_r8_otp_vol: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        (($past(vol) & ~vol & OTP_MASK) == 16'h0000));

    // R8: one-time bits never fall in the non-volatile copy
    a_r8_otp_nv: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        (($past(nv) & ~nv & OTP_MASK) == 16'h0000));

    // R10: non-volatile copy frozen while busy
    a_r10_nv_frozen: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        busy |=> $stable(nv));

    // R6: latch is clear when busy ends
    a_r6_wel_clear: assert property (@(posedge clk) disable iff (!rst_n || !nv_init_n)
        $fell(busy) |-> !wel);
endmodule

bind flash_sr_resp flash_sr_resp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n), .cs_s(cs_s),
    .miso_oe(miso_oe), .rd_phase(rd_phase_w), .vol(vol_w), .nv(nv_q),
    .busy(busy), .wel(wel_w)
);

// File: tb/flash_sr_resp_test.sv
`timescale 1ns/1ps
module flash_sr_resp_test;
    localparam int BUSY = 600;
    localparam int HP   = 3;

    logic clk = 1'b0;
    logic nv_init_n = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic oe_seen;
    logic [15:0] exp_nv  = 16'h0000;
    logic [15:0] exp_vol = 16'h0000;
    logic        exp_wel = 1'b0;

    flash_sr_resp #(.BUSY_CYC(BUSY), .NV_INIT(16'h0000)) uut (
        .clk(clk), .nv_init_n(nv_init_n), .rst_n(rst_n), .cs_n(cs_n),
        .sclk(sclk), .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
    );

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] bm(input logic [15:0] old, input logic [23:0] d, input int n);
        logic [15:0] mask, pos;
        mask = (n == 16) ? 16'h7BFC : 16'h00FC;
        pos  = (n == 16) ? {d[7:0], d[15:8]} : {8'h00, d[7:0]};
        return (old & ~mask) | (pos & mask) | (old & 16'h3900);
    endfunction

    function automatic logic [7:0] sr1(input logic b);
        return {exp_vol[7:2], exp_wel, b};
    endfunction

    function automatic logic [7:0] sr2();
        return {1'b0, exp_vol[14:11], 1'b0, exp_vol[9:8]};
    endfunction

    task automatic cs_on(input bit m3);
        sclk = m3; tick(2); cs_n = 1'b0; tick(HP);
    endtask

    task automatic cs_off(input bit m3);
        sclk = m3; tick(HP); cs_n = 1'b1; tick(6);
    endtask

    task automatic bit_out(input logic b);
        sclk = 1'b0; mosi = b; tick(HP);
        oe_seen = oe_seen | miso_oe;
        sclk = 1'b1; tick(HP);
    endtask

    task automatic send(input logic [23:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic read_byte(output logic [7:0] v, inout logic oe_all);
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0; tick(HP);
            v[i] = miso;
            oe_all = oe_all & miso_oe;
            sclk = 1'b1; tick(HP);
        end
    endtask

    task automatic rd_reg(input logic [7:0] op, input bit m3, output logic [7:0] v);
        logic oe_all;
        oe_all = 1'b1;
        cs_on(m3); send({16'h0, op}, 8); read_byte(v, oe_all); cs_off(m3);
        chk("R1 oe during read", {15'h0, oe_all}, 16'h0001);
    endtask

    task automatic cmd(input logic [7:0] op);
        cs_on(0); send({16'h0, op}, 8); cs_off(0);
    endtask

    task automatic wrsr(input logic [23:0] d, input int n);
        cs_on(0); send(24'h000001, 8); send(d, n); cs_off(0);
    endtask

    task automatic poll(output logic [7:0] first, output logic [7:0] last, output int nb);
        logic [7:0] b;
        logic oe_all;
        oe_all = 1'b1; nb = 0; first = '0; last = '0;
        cs_on(0); send(24'h000005, 8);
        for (int k = 0; k < 60; k++) begin
            read_byte(b, oe_all);
            if (k == 0) first = b;
            last = b; nb++;
            if (!b[0]) break;
        end
        cs_off(0);
    endtask

    task automatic pwr_cycle();
        rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
        exp_vol = exp_nv; exp_wel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, f, l;
        int nb;
        logic [23:0] d;
        tick(5); nv_init_n = 1'b1; rst_n = 1'b1; tick(4);

        // R9 reset state, R1 idle output off
        chk("R1 idle oe", {15'h0, miso_oe}, 16'h0);
        rd_reg(8'h05, 0, v); chk("R9 reset SR1", {8'h0, v}, {8'h0, sr1(0)});
        rd_reg(8'h35, 0, v); chk("R9 reset SR2", {8'h0, v}, {8'h0, sr2()});

        // R11 unknown opcode: driver stays off, no state change
        oe_seen = 1'b0;
        cs_on(0); send(24'h0000AA, 8); send(24'h00FFFF, 16); cs_off(0);
        chk("R11 unknown op oe", {15'h0, oe_seen}, 16'h0);
        oe_seen = 1'b0;
        cs_on(0); send(24'h000005, 8); cs_off(0);
        chk("R1 oe off in opcode", {15'h0, oe_seen}, 16'h0);
        rd_reg(8'h05, 0, v); chk("R11 SR1 unchanged", {8'h0, v}, {8'h0, sr1(0)});

        // R4 write enable
        cmd(8'h06); exp_wel = 1'b1;
        rd_reg(8'h05, 0, v); chk("R4 latch set", {8'h0, v}, {8'h0, sr1(0)});

        // R5 wrong lengths discarded
        wrsr(24'h7FFFFF, 7);  rd_reg(8'h05, 0, v); chk("R5 7 bits", {8'h0, v}, {8'h0, sr1(0)});
        wrsr(24'h1FFFFF, 9);  rd_reg(8'h05, 0, v); chk("R5 9 bits", {8'h0, v}, {8'h0, sr1(0)});
        wrsr(24'h7FFFFF, 15); rd_reg(8'h35, 0, v); chk("R5 15 bits", {8'h0, v}, {8'h0, sr2()});
        wrsr(24'h1FFFFF, 17); rd_reg(8'h35, 0, v); chk("R5 17 bits", {8'h0, v}, {8'h0, sr2()});

        // R6 non-volatile write, R3 continuous polling
        d = 24'h009C42; wrsr(d, 16);
        exp_nv = bm(exp_nv, d, 16); exp_vol = bm(exp_vol, d, 16);
        poll(f, l, nb);
        chk("R6 busy+latch first byte", {8'h0, f}, {8'h0, sr1(1)});
        exp_wel = 1'b0;
        chk("R6 idle last byte", {8'h0, l}, {8'h0, sr1(0)});
        chk("R3 R6 busy byte count", 16'(nb >= 11 && nb <= 15), 16'h1);
        rd_reg(8'h35, 0, v); chk("R6 SR2 after write", {8'h0, v}, {8'h0, sr2()});

        // R10 commands while busy are ignored
        cmd(8'h06); exp_wel = 1'b1;
        d = 24'h00E000; wrsr(d, 16);
        exp_nv = bm(exp_nv, d, 16); exp_vol = bm(exp_vol, d, 16);
        cmd(8'h50); wrsr(24'h000004, 8); cmd(8'h06);
        poll(f, l, nb);
        chk("R10 still busy", {15'h0, f[0]}, 16'h1);
        exp_wel = 1'b0;
        chk("R10 SR1 after busy", {8'h0, l}, {8'h0, sr1(0)});
        wrsr(24'h000004, 8);
        rd_reg(8'h05, 0, v); chk("R10 R6 no enable discard", {8'h0, v}, {8'h0, sr1(0)});

        // R7 volatile sweep of register 1
        for (int i = 0; i < 64; i++) begin
            d = {16'h0, 6'(i), 2'b11};
            cmd(8'h50); wrsr(d, 8); exp_vol = bm(exp_vol, d, 8);
            rd_reg(8'h05, 0, v); chk("R7 R5 vol SR1 sweep", {8'h0, v}, {8'h0, sr1(0)});
        end
        rd_reg(8'h35, 0, v); chk("R5 8-bit leaves SR2", {8'h0, v}, {8'h0, sr2()});

        // R9 power cycle restores non-volatile values
        pwr_cycle();
        rd_reg(8'h05, 0, v); chk("R9 SR1 reload", {8'h0, v}, {8'h0, sr1(0)});
        rd_reg(8'h35, 0, v); chk("R9 SR2 reload", {8'h0, v}, {8'h0, sr2()});

        // R7 arm cleared by another opcode and used up by one write
        cmd(8'h50); rd_reg(8'h05, 0, v); wrsr(24'h0000FC, 8);
        rd_reg(8'h05, 0, v); chk("R7 arm cleared", {8'h0, v}, {8'h0, sr1(0)});
        cmd(8'h50); d = 24'h000024; wrsr(d, 8); exp_vol = bm(exp_vol, d, 8);
        wrsr(24'h0000D8, 8);
        rd_reg(8'h05, 0, v); chk("R7 arm used once", {8'h0, v}, {8'h0, sr1(0)});

        // R8 R2 volatile sweep of register 2 with one-time bits
        for (int k = 0; k < 32; k++) begin
            d = {8'h00, 8'(k * 4 + 1), 8'(k * 8'h2D + 8'h11)};
            cmd(8'h50); wrsr(d, 16); exp_vol = bm(exp_vol, d, 16);
            rd_reg(8'h35, 0, v); chk("R8 R2 vol SR2 sweep", {8'h0, v}, {8'h0, sr2()});
            rd_reg(8'h05, 0, v); chk("R5 vol SR1 two-byte", {8'h0, v}, {8'h0, sr1(0)});
        end
        cmd(8'h50); wrsr(24'h000000, 16); exp_vol = bm(exp_vol, 24'h0, 16);
        rd_reg(8'h35, 0, v); chk("R8 vol one-time kept", {8'h0, v}, {8'h0, sr2()});
        pwr_cycle();
        rd_reg(8'h35, 0, v); chk("R9 vol one-time lost", {8'h0, v}, {8'h0, sr2()});

        // R8 non-volatile one-time bits
        cmd(8'h06); d = 24'h000009; wrsr(d, 16);
        exp_nv = bm(exp_nv, d, 16); exp_vol = bm(exp_vol, d, 16);
        poll(f, l, nb);
        cmd(8'h06); wrsr(24'h000000, 16);
        exp_nv = bm(exp_nv, 24'h0, 16); exp_vol = bm(exp_vol, 24'h0, 16);
        poll(f, l, nb);
        pwr_cycle();
        rd_reg(8'h35, 0, v); chk("R8 nv one-time kept", {8'h0, v}, {8'h0, sr2()});
        chk("R8 bits 8 and 11 set", {8'h0, v & 8'h09}, 16'h0009);

        // R12 mode 3 reads
        rd_reg(8'h05, 1, v); chk("R12 mode3 SR1", {8'h0, v}, {8'h0, sr1(0)});
        rd_reg(8'h35, 1, v); chk("R12 mode3 SR2", {8'h0, v}, {8'h0, sr2()});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule